// File: doc/BRIEF.md
# Branch History Ring Buffer

This block keeps the most recent branch-history records of a processor core in a circular store of `DEPTH` 64-bit entries. A producer pushes one record per cycle on the record port. The block writes it into the slot named by a write pointer and then steps the pointer forward modulo `DEPTH`. The pointer therefore always names the oldest entry, which is the next one to be overwritten. Software-visible reads name an entry by its age: entry 0 is the newest record, entry 1 the one before it, and so on. The data comes back one cycle after the request.

Every read and every clear goes through a privilege check first. The first test is whether the hypervisor has allowed the facility to a non-hypervisor state; if it has not, a hypervisor facility-unavailable pulse is raised. If that test passes, the second test is whether problem-state code has access; if it does not, an ordinary facility-unavailable pulse is raised. Both pulses carry the branch-history cause code. A faulting operation has no other effect. Reads return zero while the feature is disabled, while the monitor freeze bit is set, or when the requested age is outside the buffer.

Top module: `bhist_ring`

## Requirements
- R1: A record accepted in a cycle is written into the slot at the write pointer, and the pointer then advances, wrapping from `DEPTH-1` back to 0. After more than `DEPTH` records, only the last `DEPTH` records can be read.
- R2: A permitted read of age n, with n < `DEPTH`, returns the n-th most recent record (age 0 is the newest). The data appears on `rd_data` with `rd_valid` high in the cycle after the request.
- R3: A permitted read of age n ≥ `DEPTH` returns zero.
- R4: A permitted read returns zero while `feat_en` is low or `freeze` is high.
- R5: Records are dropped while `feat_en` is low or `freeze` is high. Stored entries and the pointer are left unchanged.
- R6: A permitted clear with `feat_en` high zeroes every entry and leaves the write pointer where it is. A clear with `feat_en` low changes nothing.
- R7: When a clear takes effect in the same cycle as a record, the clear wins and the record is dropped.
- R8: A read or clear with `hyp_state` low and `hfac_en` low raises `hfu_exc` as a single-cycle pulse in the next cycle, with `exc_cause` = 4'h9 (the default of `BH_CAUSE`). The operation is suppressed: there is no `rd_valid` and no clearing.
- R9: A read or clear that passes the hypervisor check, with `prob_state` high and `mon_access` low, raises `fu_exc` as a single-cycle pulse in the next cycle, with `exc_cause` = 4'h9. The operation is suppressed.
- R10: The hypervisor check takes precedence. When both checks fail, only `hfu_exc` is raised. `fu_exc` and `hfu_exc` are never high together.
- R11: After reset, all outputs are zero, every entry reads as zero, and the write pointer is at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid | input | 1 | Record strobe |
| rec_data | input | 64 | Record payload |
| rd_req | input | 1 | Read request strobe |
| rd_idx | input | 8 | Age of the entry to read (0 = newest) |
| clr_req | input | 1 | Clear-all strobe |
| feat_en | input | 1 | Feature enable |
| prob_state | input | 1 | Core is in problem (user) state |
| hyp_state | input | 1 | Core is in hypervisor state |
| hfac_en | input | 1 | Hypervisor allows the facility to lower states |
| mon_access | input | 1 | Monitor grants problem-state access |
| freeze | input | 1 | Monitor alert/freeze bit |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 64 | Read data |
| fu_exc | output | 1 | Facility-unavailable pulse |
| hfu_exc | output | 1 | Hypervisor facility-unavailable pulse |
| exc_cause | output | 4 | Cause code, valid with either exception pulse |

## Verification
The properties that tie each exception pulse and each zero read to the request cycle assume that the control inputs are stable across the clock edge that samples a request. They also assume that `rd_req` and `clr_req` are not raised together, because the block has only one result slot per cycle. The stimulus changes controls only on falling edges, between requests. It issues at most one read or clear per operation, and combines a clear with a record only in the case that exercises R7.

// File: rtl/bhr_pkg.sv
package bhr_pkg;
  typedef enum logic [1:0] {
    ACC_OK  = 2'd0,
    ACC_FU  = 2'd1,
    ACC_HFU = 2'd2
  } acc_res_e;
endpackage

// File: rtl/bhr_access.sv
module bhr_access
  import bhr_pkg::*;
(
  input  logic     op,
  input  logic     prob_state,
  input  logic     hyp_state,
  input  logic     hfac_en,
  input  logic     mon_access,
  output acc_res_e res
);
  always_comb begin
    res = ACC_OK;
    if (op) begin
      // hypervisor gate is evaluated first
      if (!hyp_state && !hfac_en) res = ACC_HFU;
      else if (prob_state && !mon_access) res = ACC_FU;
    end
  end
endmodule

// File: rtl/bhr_slot_calc.sv
module bhr_slot_calc #(
  parameter int DEPTH = 32,
  parameter int IDX_W = 8,
  parameter int PTR_W = 5
) (
  input  logic [PTR_W-1:0] wp,
  input  logic [IDX_W-1:0] idx,
  output logic [PTR_W-1:0] slot,
  output logic             in_range
);
  localparam int SW = PTR_W + 1;
  localparam logic [IDX_W:0] DEPTH_X = (IDX_W+1)'(DEPTH);
  localparam logic [SW-1:0]  DEPTH_S = SW'(DEPTH);
  localparam logic [SW-1:0]  DM1_S   = SW'(DEPTH - 1);

  logic [SW-1:0] sum;

  always_comb begin
    in_range = ({1'b0, idx} < DEPTH_X);
    // newest entry sits one slot behind the write pointer
    sum  = {1'b0, wp} + DM1_S - {1'b0, idx[PTR_W-1:0]};
    slot = (sum >= DEPTH_S) ? PTR_W'(sum - DEPTH_S) : sum[PTR_W-1:0];
  end
endmodule

// File: rtl/bhr_store.sv
module bhr_store #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 64,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_en,
  input  logic [PTR_W-1:0]  rd_slot,
  output logic [DATA_W-1:0] rd_slot_data,
  output logic [PTR_W-1:0]  wp
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp_nxt;
  logic              wp_ce;

  always_comb begin
    wp_ce  = wr_en && !clr_en;
    wp_nxt = (wp == LAST) ? '0 : wp + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wp <= '0;
    else if (wp_ce) wp <= wp_nxt;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic ent_we;
    assign ent_we = wp_ce && (wp == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem[i] <= '0;
      else if (clr_en) mem[i] <= '0;
      else if (ent_we) mem[i] <= wr_data;
    end
  end

  assign rd_slot_data = mem[rd_slot];
endmodule

// File: rtl/bhist_ring.sv
module bhist_ring
  import bhr_pkg::*;
#(
  parameter int          DEPTH    = 32,
  parameter int          DATA_W   = 64,
  parameter int          IDX_W    = 8,
  parameter logic [3:0]  BH_CAUSE = 4'h9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  input  logic [DATA_W-1:0] rec_data,
  input  logic              rd_req,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              clr_req,
  input  logic              feat_en,
  input  logic              prob_state,
  input  logic              hyp_state,
  input  logic              hfac_en,
  input  logic              mon_access,
  input  logic              freeze,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              fu_exc,
  output logic              hfu_exc,
  output logic [3:0]        exc_cause
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  acc_res_e          acc;
  logic              rd_go, clr_go, wr_go, rd_zero, in_range;
  logic [PTR_W-1:0]  wp, slot;
  logic [DATA_W-1:0] slot_data;

  bhr_access u_acc (
    .op(rd_req || clr_req), .prob_state(prob_state), .hyp_state(hyp_state),
    .hfac_en(hfac_en), .mon_access(mon_access), .res(acc)
  );

  bhr_slot_calc #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_slot (
    .wp(wp), .idx(rd_idx), .slot(slot), .in_range(in_range)
  );

  always_comb begin
    rd_go   = rd_req && (acc == ACC_OK);
    clr_go  = clr_req && (acc == ACC_OK) && feat_en;
    wr_go   = rec_valid && feat_en && !freeze;
    rd_zero = !feat_en || freeze || !in_range;
  end

  bhr_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_go), .wr_data(rec_data),
    .clr_en(clr_go), .rd_slot(slot), .rd_slot_data(slot_data), .wp(wp)
  );

  // output stage: next state, then registers
  logic              rd_valid_nxt, fu_nxt, hfu_nxt;
  logic [DATA_W-1:0] rd_data_nxt;
  logic [3:0]        cause_nxt;

  always_comb begin
    rd_valid_nxt = rd_go;
    rd_data_nxt  = rd_zero ? '0 : slot_data;
    fu_nxt       = (acc == ACC_FU);
    hfu_nxt      = (acc == ACC_HFU);
    cause_nxt    = (fu_nxt || hfu_nxt) ? BH_CAUSE : 4'h0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_valid  <= 1'b0;
      fu_exc    <= 1'b0;
      hfu_exc   <= 1'b0;
      exc_cause <= 4'h0;
    end else begin
      rd_valid  <= rd_valid_nxt;
      fu_exc    <= fu_nxt;
      hfu_exc   <= hfu_nxt;
      exc_cause <= cause_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rd_data <= '0;
    else if (rd_go)  rd_data <= rd_data_nxt;
  end
endmodule

// File: rtl/bhist_ring_chk.sv
module bhist_ring_chk #(
  parameter int         DEPTH    = 32,
  parameter int         DATA_W   = 64,
  parameter int         IDX_W    = 8,
  parameter logic [3:0] BH_CAUSE = 4'h9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic [IDX_W-1:0]  rd_idx,
  input logic              clr_req,
  input logic              feat_en,
  input logic              prob_state,
  input logic              hyp_state,
  input logic              hfac_en,
  input logic              mon_access,
  input logic              freeze,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              fu_exc,
  input logic              hfu_exc,
  input logic [3:0]        exc_cause
);
  localparam logic [IDX_W:0] DEPTH_X = (IDX_W+1)'(DEPTH);

  assert_exc_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fu_exc && hfu_exc));

  assert_hfu_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hfu_exc |-> $past((rd_req || clr_req) && !hyp_state && !hfac_en));

  assert_fu_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fu_exc |-> $past((rd_req || clr_req) && prob_state && !mon_access
                     && (hyp_state || hfac_en)));

  assert_exc_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fu_exc || hfu_exc) |-> (exc_cause == BH_CAUSE));

  assert_fault_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !(fu_exc || hfu_exc));

  assert_read_zero_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(!feat_en || freeze)) |-> (rd_data == '0));

  assert_read_zero_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past({1'b0, rd_idx} >= DEPTH_X)) |-> (rd_data == '0));
endmodule

bind bhist_ring bhist_ring_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W), .BH_CAUSE(BH_CAUSE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_idx(rd_idx),
  .clr_req(clr_req), .feat_en(feat_en), .prob_state(prob_state),
  .hyp_state(hyp_state), .hfac_en(hfac_en), .mon_access(mon_access),
  .freeze(freeze), .rd_valid(rd_valid), .rd_data(rd_data),
  .fu_exc(fu_exc), .hfu_exc(hfu_exc), .exc_cause(exc_cause)
);

// File: tb/bhist_ring_bench.sv
module bhist_ring_bench;
  localparam int         CLK_PERIOD = 10;
  localparam int         N          = 32;
  localparam logic [3:0] EXP_CAUSE  = 4'h9;

  logic        clk, rst_n;
  logic        rec_valid, rd_req, clr_req;
  logic [63:0] rec_data;
  logic [7:0]  rd_idx;
  logic        feat_en, prob_state, hyp_state, hfac_en, mon_access, freeze;
  logic        rd_valid, fu_exc, hfu_exc;
  logic [63:0] rd_data;
  logic [3:0]  exc_cause;

  bhist_ring u_bhist_ring (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_data(rec_data),
    .rd_req(rd_req), .rd_idx(rd_idx), .clr_req(clr_req), .feat_en(feat_en),
    .prob_state(prob_state), .hyp_state(hyp_state), .hfac_en(hfac_en),
    .mon_access(mon_access), .freeze(freeze), .rd_valid(rd_valid),
    .rd_data(rd_data), .fu_exc(fu_exc), .hfu_exc(hfu_exc), .exc_cause(exc_cause)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit mon_on = 0, finished = 0;

  // kind: 0 read data, 1 facility fault, 2 hypervisor fault
  int          q_kind[$];
  logic [63:0] q_data[$];
  string       q_req[$];

  logic [63:0] mdl [N];
  int          mwp = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    if (rd_valid || fu_exc || hfu_exc) begin
      int k;
      k = (int'(rd_valid) + int'(fu_exc) + int'(hfu_exc) > 1) ? 3 : hfu_exc ? 2 : fu_exc ? 1 : 0;
      if (q_kind.size() == 0) chk(0, "R2 unexpected output", 64'(k), 64'hffff);
      else begin
        int ek; logic [63:0] ed; string er;
        ek = q_kind.pop_front(); ed = q_data.pop_front(); er = q_req.pop_front();
        chk(k == ek, {er, " kind"}, 64'(k), 64'(ek));
        if (k == ek) begin
          if (k == 0) chk(rd_data == ed, er, rd_data, ed);
          else        chk(exc_cause == EXP_CAUSE, {er, " cause"}, 64'(exc_cause), 64'(EXP_CAUSE));
        end
      end
    end
  end

  function automatic int fault();
    if (!hyp_state && !hfac_en) return 2;
    if (prob_state && !mon_access) return 1;
    return 0;
  endfunction

  task automatic set_ctl(input bit en, input bit frz, input bit pr, input bit hv, input bit hfe, input bit mon);
    @(negedge clk);
    feat_en = en; freeze = frz; prob_state = pr; hyp_state = hv; hfac_en = hfe; mon_access = mon;
  endtask

  task automatic record(input logic [63:0] d);
    @(negedge clk);
    rec_valid = 1'b1; rec_data = d;
    if (feat_en && !freeze) begin mdl[mwp] = d; mwp = (mwp + 1) % N; end
    @(negedge clk);
    rec_valid = 1'b0;
  endtask

  task automatic do_read(input int idx, input string req);
    int f;
    @(negedge clk);
    rd_req = 1'b1; rd_idx = 8'(idx);
    f = fault();
    q_kind.push_back(f); q_req.push_back(req);
    if (f != 0 || !feat_en || freeze || idx >= N) q_data.push_back(64'h0);
    else q_data.push_back(mdl[(mwp + N - 1 - idx) % N]);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic do_clear(input bit with_rec, input logic [63:0] d, input string req);
    int f;
    @(negedge clk);
    clr_req = 1'b1; rec_valid = with_rec; rec_data = d;
    f = fault();
    if (f != 0) begin q_kind.push_back(f); q_data.push_back(64'h0); q_req.push_back(req); end
    if (f == 0 && feat_en) begin
      for (int i = 0; i < N; i++) mdl[i] = '0;
    end else if (with_rec && feat_en && !freeze) begin
      mdl[mwp] = d; mwp = (mwp + 1) % N;
    end
    @(negedge clk);
    clr_req = 1'b0; rec_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      chk(0, "watchdog", 64'h0, 64'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) mdl[i] = '0;
    rst_n = 1'b0; rec_valid = 0; rd_req = 0; clr_req = 0; rec_data = '0; rd_idx = '0;
    feat_en = 1; freeze = 0; prob_state = 0; hyp_state = 1; hfac_en = 1; mon_access = 1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(!rd_valid && !fu_exc && !hfu_exc && exc_cause == 0 && rd_data == 0,
        "R11 outputs after reset", {rd_data[59:0], exc_cause}, 64'h0);
    mon_on = 1;
    do_read(0, "R11 entry zero after reset");
    do_read(N - 1, "R11 oldest zero after reset");

    // R2: a few records, newest first
    for (int i = 1; i <= 5; i++) record(64'hA000_0000_0000_0000 | 64'(i));
    for (int i = 0; i <= 5; i++) do_read(i, "R2 age read");

    // R1: wrap past the end of the store
    for (int i = 0; i < 40; i++) record(64'h5500_0000_0000_0000 + 64'(i * 7));
    for (int i = 0; i < N; i++) do_read(i, "R1 wrapped read");

    // R3: ages beyond the store
    do_read(N, "R3 age at depth");
    do_read(200, "R3 large age");

    // R4/R5: freeze and disable
    set_ctl(1, 1, 0, 1, 1, 1);
    do_read(0, "R4 read while frozen");
    record(64'hDEAD_0000_0000_0001);
    set_ctl(0, 0, 0, 1, 1, 1);
    do_read(1, "R4 read while disabled");
    record(64'hDEAD_0000_0000_0002);
    do_clear(0, '0, "R6 clear while disabled");
    set_ctl(1, 0, 0, 1, 1, 1);
    do_read(0, "R5 record ignored");
    do_read(1, "R6 disabled clear had no effect");

    // R8: hypervisor fault on read and clear
    set_ctl(1, 0, 0, 0, 0, 1);
    do_read(0, "R8 hv fault read");
    do_clear(0, '0, "R8 hv fault clear");
    // R10: both faults, hypervisor wins
    set_ctl(1, 0, 1, 0, 0, 0);
    do_read(0, "R10 precedence read");
    // R9: problem-state fault
    set_ctl(1, 0, 1, 1, 1, 0);
    do_read(2, "R9 pr fault read");
    do_clear(0, '0, "R9 pr fault clear");
    set_ctl(1, 0, 1, 0, 1, 0);
    do_read(3, "R9 pr fault in guest state");
    set_ctl(1, 0, 1, 0, 1, 1);
    do_read(0, "R8 suppressed clear kept data");

    // R6: real clear keeps pointer
    set_ctl(1, 0, 0, 1, 1, 1);
    do_clear(0, '0, "R6 clear");
    do_read(0, "R6 zero after clear");
    do_read(17, "R6 zero after clear");
    record(64'h1234_5678_9ABC_DEF0);
    do_read(0, "R6 record after clear");
    do_read(1, "R6 older still zero");

    // R7: clear and record together
    record(64'h0BAD_F00D_0000_0001);
    do_clear(1, 64'hFFFF_0000_0000_0007, "R7 clear with record");
    do_read(0, "R7 record dropped");
    record(64'h7777_0000_0000_0000);
    do_read(0, "R7 pointer after clear");

    repeat (4) @(negedge clk);
    chk(q_kind.size() == 0, "R2 all results returned", 64'(q_kind.size()), 64'h0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule